// File: doc/BRIEF.md
# Banked Data-Memory File with Pointer Indirection

This block is the data memory of a small 8-bit processor. An instruction supplies a 5-bit file address. A 7-bit pointer register selects a bank and can also name a location. From these two values the block picks one byte out of four banks of 32 locations. The lower sixteen locations are shared: whichever bank is selected, they reach the same storage. The upper sixteen locations are private to each bank.

File address 00h holds no storage. Accessing it redirects the access to the location the pointer names. The pointer lives at location 04h and is read and written like any other file location. The special-function locations in the shared half, other than the pointer, are modelled as plain bytes.

The block has one combinational read port and one write port that is committed on the clock edge. Each port carries an address, data and an enable. Every access is first classified as one of four kinds:

- **null**: the indirect self-reference.
- **pointer**: location 04h.
- **shared**: the low half.
- **banked**: the high half.

The classification then steers the access. There is no sequential control beyond the pointer register itself.

Top module: `banked_regfile`

## Requirements
- R1: A direct access (file address 01h–1Fh) resolves to bank = pointer bits 6:5 and location = the file address.
- R2: File address 00h is indirect: it resolves to bank = pointer bits 6:5 and location = pointer bits 4:0.
- R3: Locations 01h–0Fh (other than 04h) hold one shared byte each, reached identically from all four banks.
- R4: Locations 10h–1Fh are separate storage in each of the four banks; a write in one bank leaves the same location in the other banks unchanged.
- R5: An indirect read whose pointer bits 4:0 are 00h returns 00h.
- R6: An indirect write whose pointer bits 4:0 are 00h changes no location and leaves the pointer unchanged.
- R7: Location 04h, in any bank and by direct or indirect access, is the pointer. A write loads write-data bits 6:0. A read returns the pointer with bit 7 = 0. Reset clears the pointer to 00h.
- R8: Reads are combinational from the currently resolved location. Writes take effect at the rising clock edge where the write enable is high, so a read of the same location in that cycle returns the old value.
- R9: With the read enable low the read data is 00h; with the write enable low no location or pointer changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset (clears the pointer) |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 5 | Read file address from the instruction |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write file address from the instruction |
| wr_data | input | 8 | Write data |

## Verification
The bench first sweeps every direct address in each of the four banks. This separates the aliased low half from the per-bank high half and catches a bank decode that ignores or misuses the pointer bits.

Directed cases then exercise three things:
- The pointer naming itself, which must read zero and swallow writes.
- The pointer reached indirectly through 00h.
- A read and a write to the same location in one cycle, which shows whether the write lands at the edge or leaks through combinationally.

A long random mix, with the pointer rewritten both directly and indirectly, finally checks every read against a byte-level model.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

    // Kind of storage an address resolves to
    typedef enum logic [1:0] {
        ACC_NULL   = 2'd0,  // indirect access naming the indirect slot itself
        ACC_PTR    = 2'd1,  // the pointer register
        ACC_SHARED = 2'd2,  // low half, common to all banks
        ACC_BANKED = 2'd3   // high half, private to each bank
    } acc_kind_e;

endpackage

// File: rtl/rf_addr_resolve.sv
`timescale 1ns/1ps
module rf_addr_resolve
    import rf_pkg::*;
#(
    parameter int LOC_W   = 5,
    parameter int BANK_W  = 2,
    parameter int PTR_LOC = 4
) (
    input  logic [LOC_W-1:0]        addr,
    input  logic [BANK_W+LOC_W-1:0] ptr,
    output acc_kind_e               kind,
    output logic [BANK_W-1:0]       bank,
    output logic [LOC_W-2:0]        slot
);
    localparam int PTR_W = BANK_W + LOC_W;

    logic [LOC_W-1:0] eff_loc;

    always_comb begin
        // address zero is the indirect port: take the location from the pointer
        eff_loc = (addr == '0) ? ptr[LOC_W-1:0] : addr;
        bank    = ptr[PTR_W-1:LOC_W];
        slot    = eff_loc[LOC_W-2:0];
        if (eff_loc == '0)
            kind = ACC_NULL;
        else if (eff_loc == LOC_W'(PTR_LOC))
            kind = ACC_PTR;
        else if (!eff_loc[LOC_W-1])
            kind = ACC_SHARED;
        else
            kind = ACC_BANKED;
    end
endmodule

// File: rtl/rf_shared_store.sv
`timescale 1ns/1ps
module rf_shared_store #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_W-1:0] rslot,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << SLOT_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[wslot] <= wdata;
    end

    assign rdata = mem[rslot];
endmodule

// File: rtl/rf_banked_store.sv
`timescale 1ns/1ps
module rf_banked_store #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BANK_W-1:0] wbank,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BANK_W-1:0] rbank,
    input  logic [SLOT_W-1:0] rslot,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << SLOT_W;
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0][DATA_W-1:0] lane;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wbank == BANK_W'(b)))
                mem[wslot] <= wdata;
        end

        assign lane[b] = mem[rslot];
    end

    assign rdata = lane[rbank];
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LOC_W   = 5,
    parameter int BANK_W  = 2,
    parameter int PTR_LOC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [LOC_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LOC_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int PTR_W  = BANK_W + LOC_W;
    localparam int SLOT_W = LOC_W - 1;

    logic [PTR_W-1:0]  ptr_q;

    acc_kind_e         rd_kind,  wr_kind;
    logic [BANK_W-1:0] rd_bank,  wr_bank;
    logic [SLOT_W-1:0] rd_slot,  wr_slot;

    logic              ptr_we, sh_we, bk_we;
    logic [DATA_W-1:0] sh_rdata, bk_rdata;
    logic [DATA_W-1:0] mux_data;

    rf_addr_resolve #(.LOC_W(LOC_W), .BANK_W(BANK_W), .PTR_LOC(PTR_LOC)) u_rd_res (
        .addr (rd_addr),
        .ptr  (ptr_q),
        .kind (rd_kind),
        .bank (rd_bank),
        .slot (rd_slot)
    );

    rf_addr_resolve #(.LOC_W(LOC_W), .BANK_W(BANK_W), .PTR_LOC(PTR_LOC)) u_wr_res (
        .addr (wr_addr),
        .ptr  (ptr_q),
        .kind (wr_kind),
        .bank (wr_bank),
        .slot (wr_slot)
    );

    // Write steering by access kind
    always_comb begin
        ptr_we = 1'b0;
        sh_we  = 1'b0;
        bk_we  = 1'b0;
        unique case (wr_kind)
            ACC_NULL:   ;
            ACC_PTR:    ptr_we = wr_en;
            ACC_SHARED: sh_we  = wr_en;
            ACC_BANKED: bk_we  = wr_en;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_we)
            ptr_q <= wr_data[PTR_W-1:0];
    end

    rf_shared_store #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_shared (
        .clk   (clk),
        .we    (sh_we),
        .wslot (wr_slot),
        .wdata (wr_data),
        .rslot (rd_slot),
        .rdata (sh_rdata)
    );

    rf_banked_store #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .BANK_W(BANK_W)) u_banked (
        .clk   (clk),
        .we    (bk_we),
        .wbank (wr_bank),
        .wslot (wr_slot),
        .wdata (wr_data),
        .rbank (rd_bank),
        .rslot (rd_slot),
        .rdata (bk_rdata)
    );

    // Read selection by access kind
    always_comb begin
        unique case (rd_kind)
            ACC_NULL:   mux_data = '0;
            ACC_PTR:    mux_data = DATA_W'(ptr_q);
            ACC_SHARED: mux_data = sh_rdata;
            ACC_BANKED: mux_data = bk_rdata;
            default:    mux_data = '0;
        endcase
    end

    assign rd_data = rd_en ? mux_data : '0;
endmodule

// File: rtl/banked_regfile_checker.sv
`timescale 1ns/1ps
module banked_regfile_checker #(
    parameter int DATA_W  = 8,
    parameter int LOC_W   = 5,
    parameter int BANK_W  = 2,
    parameter int PTR_LOC = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rd_en,
    input logic [LOC_W-1:0]         rd_addr,
    input logic [DATA_W-1:0]        rd_data,
    input logic                     wr_en,
    input logic [LOC_W-1:0]         wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic [BANK_W+LOC_W-1:0]  ptr_q
);
    localparam int PTR_W = BANK_W + LOC_W;

    // R9: disabled read port drives zero
    a_r9_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);

    // R5: indirect read of the indirect slot yields zero
    a_r5_null_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == '0 && ptr_q[LOC_W-1:0] == '0) |-> rd_data == '0);

    // R7: direct read of the pointer location returns the pointer
    a_r7_ptr_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == LOC_W'(PTR_LOC)) |-> rd_data == DATA_W'(ptr_q));

    // R7: direct write of the pointer location loads it
    a_r7_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LOC_W'(PTR_LOC)) |=> ptr_q == $past(wr_data[PTR_W-1:0]));

    // R6 / R9: pointer holds unless a write reaches location 04h
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_addr != LOC_W'(PTR_LOC) &&
                    !(wr_addr == '0 && ptr_q[LOC_W-1:0] == LOC_W'(PTR_LOC))))
        |=> $stable(ptr_q));

    // R8: a direct write is visible to a read of the same address on the next cycle
    a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_addr) != '0 && $past(wr_addr) != LOC_W'(PTR_LOC) &&
         rd_en && rd_addr == $past(wr_addr) && $stable(ptr_q))
        |-> rd_data == $past(wr_data));
endmodule

bind banked_regfile banked_regfile_checker #(
    .DATA_W(DATA_W), .LOC_W(LOC_W), .BANK_W(BANK_W), .PTR_LOC(PTR_LOC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ptr_q   (ptr_q)
);

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd_en;
    logic [4:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // byte-level model
    logic [7:0] m_shared [16];
    logic [7:0] m_bank   [4][16];
    logic [6:0] m_ptr;

    always #2.5 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    function automatic logic [7:0] m_read(input logic [4:0] a);
        logic [4:0] loc;
        logic [1:0] bk;
        bk  = m_ptr[6:5];
        loc = (a == 5'd0) ? m_ptr[4:0] : a;
        if (loc == 5'd0)      return 8'h00;
        else if (loc == 5'd4) return {1'b0, m_ptr};
        else if (loc < 5'd16) return m_shared[loc[3:0]];
        else                  return m_bank[bk][loc[3:0]];
    endfunction

    task automatic m_write(input logic [4:0] a, input logic [7:0] d);
        logic [4:0] loc;
        logic [1:0] bk;
        bk  = m_ptr[6:5];
        loc = (a == 5'd0) ? m_ptr[4:0] : a;
        if (loc == 5'd0)      ;
        else if (loc == 5'd4) m_ptr = d[6:0];
        else if (loc < 5'd16) m_shared[loc[3:0]] = d;
        else                  m_bank[bk][loc[3:0]] = d;
    endtask

    // One cycle: drive at falling edge, check before rising edge, commit model after it
    task automatic cyc(input bit re, input logic [4:0] ra,
                       input bit we, input logic [4:0] wa, input logic [7:0] wd,
                       input bit chk, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        #1;
        if (chk) begin
            exp = re ? m_read(ra) : 8'h00;
            checks++;
            if (rd_data !== exp) begin
                errors++;
                $display("FAIL %s addr=%02h ptr=%02h actual=%02h expected=%02h",
                         tag, ra, m_ptr, rd_data, exp);
            end
        end
        @(posedge clk);
        if (we) m_write(wa, wd);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        cyc(1'b1, a, 1'b0, 5'd0, 8'h00, 1'b1, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        cyc(1'b0, 5'd0, 1'b1, a, d, 1'b0, "");
    endtask

    task automatic set_ptr(input logic [6:0] p);
        wr(5'd4, {1'b0, p});
    endtask

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 1'b0; rd_en = 1'b0; rd_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        m_ptr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R7: pointer is clear after reset
        rd(5'd4, "R7 reset pointer");

        // fill every storage byte in every bank
        for (int b = 0; b < 4; b++) begin
            set_ptr(7'(b << 5));
            for (int a = 1; a < 32; a++)
                if (a != 4) wr(5'(a), 8'($urandom));
        end

        // R1 / R3 / R4: full direct sweep of each bank
        for (int b = 0; b < 4; b++) begin
            set_ptr(7'(b << 5));
            for (int a = 1; a < 32; a++) rd(5'(a), "R1 direct sweep");
        end

        // R3: low half written from bank 2 is seen from bank 0
        set_ptr(7'h40); wr(5'h07, 8'hA5);
        set_ptr(7'h00); rd(5'h07, "R3 alias low half");
        set_ptr(7'h60); rd(5'h0B, "R3 alias low half bank 3");

        // R4: same high location in banks 1 and 3 stays distinct
        set_ptr(7'h20); wr(5'h15, 8'h11);
        set_ptr(7'h60); wr(5'h15, 8'h33);
        set_ptr(7'h20); rd(5'h15, "R4 bank1 distinct");
        set_ptr(7'h60); rd(5'h15, "R4 bank3 distinct");

        // R2: indirect read and write through 00h
        set_ptr(7'h35); rd(5'd0, "R2 indirect read bank1 15h");
        wr(5'd0, 8'h5C);
        set_ptr(7'h20); rd(5'h15, "R2 indirect write landed");
        set_ptr(7'h09); rd(5'd0, "R2 indirect read shared 09h");

        // R7: pointer reached indirectly (ptr names 04h)
        set_ptr(7'h64); rd(5'd0, "R7 indirect pointer read");
        wr(5'd0, 8'h2A); rd(5'd4, "R7 indirect pointer write");

        // R5 / R6: pointer names the indirect slot itself
        set_ptr(7'h40); rd(5'd0, "R5 null indirect read");
        wr(5'd0, 8'hFF);
        rd(5'd4, "R6 pointer unchanged");
        for (int a = 1; a < 32; a++) rd(5'(a), "R6 bank2 unchanged");
        set_ptr(7'h00);
        for (int a = 16; a < 32; a++) rd(5'(a), "R6 bank0 unchanged");

        // R8: same-cycle read returns old, next cycle new
        set_ptr(7'h20);
        cyc(1'b1, 5'h12, 1'b1, 5'h12, 8'h9E, 1'b1, "R8 same-cycle old value");
        rd(5'h12, "R8 next-cycle new value");
        cyc(1'b1, 5'h0D, 1'b1, 5'h0D, 8'h4F, 1'b1, "R8 same-cycle old shared");
        rd(5'h0D, "R8 next-cycle new shared");

        // R9: read disable and write disable
        cyc(1'b0, 5'h12, 1'b0, 5'd0, 8'h00, 1'b1, "R9 read disabled");
        cyc(1'b0, 5'd0, 1'b0, 5'h12, 8'h77, 1'b0, "");
        rd(5'h12, "R9 write disabled");
        cyc(1'b0, 5'd0, 1'b0, 5'd4, 8'h7F, 1'b0, "");
        rd(5'd4, "R9 pointer write disabled");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] ra, wa;
            logic [7:0] wd;
            bit re, we;
            re = ($urandom % 8) != 0;
            we = ($urandom % 2) != 0;
            ra = 5'($urandom);
            wa = ($urandom % 6 == 0) ? 5'd4 : 5'($urandom);
            wd = 8'($urandom);
            cyc(re, ra, we, wa, wd, 1'b1, "R1/R2/R8 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule